// File: doc/BRIEF.md
# Prioritized Autovector Interrupt Controller

This block collects thirteen level-sensitive interrupt sources, numbered 1 to 13, and presents one request to the processor. The request is a 3-bit interrupt level and an 8-bit vector. Each source is sampled into a pending register every cycle. A mask register can block any source. Each source also has an 8-bit control byte. Its five low bits rank the source: bits 4:2 give the interrupt level and bits 1:0 give the order within that level. Bit 7 selects whether the source is autovectored.

Among the unmasked pending sources, the one with the strictly largest rank wins. A winner at level 0 is not presented. An autovectored winner gets vector 24 plus its level. Any other winner takes a programmed vector. The software-watchdog source (8) and the two serial-port sources (12 and 13) each have their own vector register. All other sources fall back to 0x0F. Software programs the block through a simple byte-addressed register port, and the outputs are registered.

Top module: `pic_irq_ctrl`

## Requirements
- R1: The active set is pending AND NOT mask. A mask bit of 1 (register at offset 0x36, bit i = source i) blocks source i, and an empty active set gives level 0.
- R2: The rank of a source is bits 4:0 of its control byte. The strictly largest rank among active sources wins, so when ranks tie the lowest-numbered source wins.
- R3: When the winning rank is below 4, the outputs are level 0 and vector 0.
- R4: The output level is bits 4:2 of the winner's control byte.
- R5: When bit 7 of the winner's control byte is set, the vector is 24 plus the level.
- R6: Otherwise the vector comes from a programmed register. Source 8 uses the watchdog vector register (0x44). Sources 12 and 13 use serial vector registers 0 (0x45) and 1 (0x46). Every other source gives 0x0F.
- R7: After reset the mask reads 0x3FFE, the watchdog vector reads 0x0F, both serial vectors read 0x00, and the outputs are level 0 and vector 0.
- R8: Control byte i sits at offset 0x14+i-1. Sources 1 to 7 reset to 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C. Source 8 resets to 0x1C, sources 9 to 11 to 0x80, and sources 12 and 13 to 0x00.
- R9: The pending register at 0x3A (bit i = source i, bit 0 reads 0) holds the value of the source inputs from the previous clock. Read data appears one cycle after the address.
- R10: The outputs reflect a change to pending, mask or control one cycle after that register changes. A source input therefore reaches the outputs in two cycles and a register write in one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 13 | Level-sensitive source inputs, bit i = source i |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data for reg_addr |
| irq_level | output | 3 | Presented interrupt level, 0 = none |
| irq_vector | output | 8 | Presented vector |

## Verification
The assertions assume that reset is held for at least one clock before any check applies. They also assume that reg_wr and reg_addr are stable at each rising edge, so one write lands per cycle and each control byte changes only through its own offset. The stimulus changes inputs only on falling edges. It issues writes one at a time and releases the strobe before the next check. It samples outputs two falling edges after a source change and one or two after a write, which matches the register stages named in R10. This lets the bench tell a late update from an early one.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int CTRL_W = 8;
  localparam int RANK_W = 5;

  // Reset value of a source control byte
  function automatic logic [CTRL_W-1:0] ctrl_reset(input int idx);
    if (idx >= 1 && idx <= 7)      return CTRL_W'(idx * 4);
    else if (idx == 8)             return 8'h1C;
    else if (idx >= 9 && idx <= 11) return 8'h80;
    else                           return 8'h00;
  endfunction
endpackage

// File: rtl/pic_regfile.sv
module pic_regfile #(
  parameter int NUM_SRC   = 13,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int CTRL_BASE = 'h14,
  parameter int MASK_ADDR = 'h36,
  parameter int PEND_ADDR = 'h3A,
  parameter int WDV_ADDR  = 'h44,
  parameter int UV0_ADDR  = 'h45,
  parameter int UV1_ADDR  = 'h46,
  parameter int WDV_RST   = 'h0F
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_SRC:1]              src_i,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [NUM_SRC:0][pic_pkg::CTRL_W-1:0] ctrl_o,
  output logic [NUM_SRC:0]              mask_o,
  output logic [NUM_SRC:0]              pend_o,
  output logic [7:0]                    wdv_o,
  output logic [7:0]                    uv0_o,
  output logic [7:0]                    uv1_o
);
  import pic_pkg::*;

  localparam logic [NUM_SRC:0] MASK_RST = {{NUM_SRC{1'b1}}, 1'b0};

  logic [CTRL_W-1:0] ctrl_q [NUM_SRC+1];
  logic [NUM_SRC:0]  mask_q, pend_q;
  logic [7:0]        wdv_q, uv0_q, uv1_q;
  logic [DATA_W-1:0] rd_next, rdata_q;

  assign ctrl_q[0]  = '0;
  assign ctrl_o[0]  = '0;

  for (genvar i = 1; i <= NUM_SRC; i++) begin : g_ctrl
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CTRL_BASE + i - 1);
    always_ff @(posedge clk) begin
      if (rst)                        ctrl_q[i] <= ctrl_reset(i);
      else if (wr_i && addr_i == MY_ADDR) ctrl_q[i] <= wdata_i[CTRL_W-1:0];
    end
    assign ctrl_o[i] = ctrl_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= MASK_RST;
      pend_q <= '0;
      wdv_q  <= 8'(WDV_RST);
      uv0_q  <= '0;
      uv1_q  <= '0;
    end else begin
      pend_q <= {src_i, 1'b0};
      if (wr_i) begin
        if (addr_i == ADDR_W'(MASK_ADDR)) mask_q <= {wdata_i[NUM_SRC:1], 1'b0};
        if (addr_i == ADDR_W'(WDV_ADDR))  wdv_q  <= wdata_i[7:0];
        if (addr_i == ADDR_W'(UV0_ADDR))  uv0_q  <= wdata_i[7:0];
        if (addr_i == ADDR_W'(UV1_ADDR))  uv1_q  <= wdata_i[7:0];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr_i == ADDR_W'(MASK_ADDR)) rd_next = DATA_W'(mask_q);
    if (addr_i == ADDR_W'(PEND_ADDR)) rd_next = DATA_W'(pend_q);
    if (addr_i == ADDR_W'(WDV_ADDR))  rd_next = DATA_W'(wdv_q);
    if (addr_i == ADDR_W'(UV0_ADDR))  rd_next = DATA_W'(uv0_q);
    if (addr_i == ADDR_W'(UV1_ADDR))  rd_next = DATA_W'(uv1_q);
    for (int i = 1; i <= NUM_SRC; i++)
      if (addr_i == ADDR_W'(CTRL_BASE + i - 1)) rd_next = DATA_W'(ctrl_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;
  assign mask_o  = mask_q;
  assign pend_o  = pend_q;
  assign wdv_o   = wdv_q;
  assign uv0_o   = uv0_q;
  assign uv1_o   = uv1_q;

  // R7: first cycle out of reset sees every source blocked
  a_r7_mask_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == MASK_RST && wdv_q == 8'(WDV_RST)));

  // R9: pending follows the inputs by one clock
  a_r9_pend_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pend_q[NUM_SRC:1] == $past(src_i) && !pend_q[0]);
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NUM_SRC = 13,
  parameter int LVL_MIN = 4,
  parameter int ID_W    = $clog2(NUM_SRC + 1)
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [NUM_SRC:0]                       active_i,
  input  logic [NUM_SRC:0][pic_pkg::CTRL_W-1:0]  ctrl_i,
  output logic                                   win_valid_o,
  output logic [ID_W-1:0]                        win_id_o,
  output logic [pic_pkg::CTRL_W-1:0]             win_ctrl_o
);
  import pic_pkg::*;

  logic [RANK_W-1:0] best;
  logic [ID_W-1:0]   id;

  // strictly-greater compare in ascending order keeps the lowest index on ties
  always_comb begin
    best = '0;
    id   = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (active_i[i] && ctrl_i[i][RANK_W-1:0] > best) begin
        best = ctrl_i[i][RANK_W-1:0];
        id   = ID_W'(i);
      end
    end
  end

  assign win_valid_o = best >= RANK_W'(LVL_MIN);
  assign win_id_o    = id;
  assign win_ctrl_o  = ctrl_i[id];

  // R2: a presented winner is always an active source
  a_r2_winner_active: assert property (@(posedge clk) disable iff (rst)
    win_valid_o |-> active_i[win_id_o]);

  // R3: a presented winner carries a nonzero level
  a_r3_level_nonzero: assert property (@(posedge clk) disable iff (rst)
    win_valid_o |-> win_ctrl_o[4:2] != 3'd0);
endmodule

// File: rtl/pic_vector_stage.sv
module pic_vector_stage #(
  parameter int NUM_SRC   = 13,
  parameter int ID_W      = $clog2(NUM_SRC + 1),
  parameter int WDOG_SRC  = 8,
  parameter int UART0_SRC = 12,
  parameter int UART1_SRC = 13,
  parameter int AUTO_BASE = 24,
  parameter int DFLT_VEC  = 'h0F,
  parameter int AUTO_BIT  = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       win_valid_i,
  input  logic [ID_W-1:0]            win_id_i,
  input  logic [pic_pkg::CTRL_W-1:0] win_ctrl_i,
  input  logic [7:0]                 wdv_i,
  input  logic [7:0]                 uv0_i,
  input  logic [7:0]                 uv1_i,
  output logic [2:0]                 level_o,
  output logic [7:0]                 vector_o
);
  logic [2:0] lvl;
  logic [7:0] vec;

  always_comb begin
    lvl = win_ctrl_i[4:2];
    if (win_ctrl_i[AUTO_BIT])               vec = 8'(AUTO_BASE) + {5'd0, lvl};
    else if (win_id_i == ID_W'(WDOG_SRC))   vec = wdv_i;
    else if (win_id_i == ID_W'(UART0_SRC))  vec = uv0_i;
    else if (win_id_i == ID_W'(UART1_SRC))  vec = uv1_i;
    else                                    vec = 8'(DFLT_VEC);
  end

  always_ff @(posedge clk) begin
    if (rst || !win_valid_i) begin
      level_o  <= '0;
      vector_o <= '0;
    end else begin
      level_o  <= lvl;
      vector_o <= vec;
    end
  end

  // R3: nothing presented after a cycle without a winner
  a_r3_quiet: assert property (@(posedge clk) disable iff (rst)
    !win_valid_i |=> level_o == 3'd0 && vector_o == 8'd0);

  // R4: level equals the winner's level field one cycle later
  a_r4_level_field: assert property (@(posedge clk) disable iff (rst)
    win_valid_i |=> level_o == $past(win_ctrl_i[4:2]));

  // R5: autovectored winner maps to base plus level
  a_r5_autovector: assert property (@(posedge clk) disable iff (rst)
    win_valid_i && win_ctrl_i[AUTO_BIT] |=> vector_o == 8'(AUTO_BASE) + {5'd0, level_o});
endmodule

// File: rtl/pic_irq_ctrl.sv
module pic_irq_ctrl #(
  parameter int NUM_SRC = 13,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SRC:1]  irq_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [2:0]        irq_level,
  output logic [7:0]        irq_vector
);
  import pic_pkg::*;

  localparam int ID_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC:0][CTRL_W-1:0] ctrl;
  logic [NUM_SRC:0]             mask, pend, active;
  logic [7:0]                   wdv, uv0, uv1;
  logic                         win_valid;
  logic [ID_W-1:0]              win_id;
  logic [CTRL_W-1:0]            win_ctrl;

  pic_regfile #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .src_i(irq_in), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .ctrl_o(ctrl), .mask_o(mask),
    .pend_o(pend), .wdv_o(wdv), .uv0_o(uv0), .uv1_o(uv1)
  );

  assign active = pend & ~mask;

  pic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk(clk), .rst(rst), .active_i(active), .ctrl_i(ctrl),
    .win_valid_o(win_valid), .win_id_o(win_id), .win_ctrl_o(win_ctrl)
  );

  pic_vector_stage #(.NUM_SRC(NUM_SRC)) u_vec (
    .clk(clk), .rst(rst), .win_valid_i(win_valid), .win_id_i(win_id),
    .win_ctrl_i(win_ctrl), .wdv_i(wdv), .uv0_i(uv0), .uv1_i(uv1),
    .level_o(irq_level), .vector_o(irq_vector)
  );

  // R1: fully blocked sources never reach the processor
  a_r1_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (pend & ~mask) == '0 |=> irq_level == 3'd0);
endmodule

// File: tb/tb_pic_irq_ctrl.sv
module tb_pic_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:1] irq_in = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vector;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pic_irq_ctrl dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_level(irq_level),
    .irq_vector(irq_vector)
  );

  function automatic logic [7:0] exp_ctrl_rst(input int i);
    case (i)
      1: return 8'h04;  2: return 8'h08;  3: return 8'h0C;  4: return 8'h10;
      5: return 8'h14;  6: return 8'h18;  7: return 8'h1C;  8: return 8'h1C;
      9, 10, 11: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [15:0] exp);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    check(req, reg_rdata, exp);
  endtask

  // write, then wait one more edge for the output register
  task automatic wr_settle(input logic [7:0] a, input logic [15:0] d);
    wr(a, d);
    @(negedge clk);
  endtask

  task automatic out_check(input string req, input logic [2:0] lvl, input logic [7:0] vec);
    check({req, " level"}, 16'(irq_level), 16'(lvl));
    check({req, " vector"}, 16'(irq_vector), 16'(vec));
  endtask

  task automatic t_reset;
    out_check("R7 reset outputs", 3'd0, 8'h00);
    rd_check("R7 mask reset", 8'h36, 16'h3FFE);
    rd_check("R7 wdog vec reset", 8'h44, 16'h000F);
    rd_check("R7 uart0 vec reset", 8'h45, 16'h0000);
    rd_check("R7 uart1 vec reset", 8'h46, 16'h0000);
    for (int i = 1; i <= 13; i++)
      rd_check("R8 ctrl reset", 8'(8'h14 + i - 1), 16'(exp_ctrl_rst(i)));
  endtask

  task automatic t_masked;
    @(negedge clk);
    irq_in = '1;
    @(negedge clk);
    @(negedge clk);
    out_check("R1 all masked", 3'd0, 8'h00);
    rd_check("R9 pending", 8'h3A, 16'h3FFE);
  endtask

  task automatic t_single;
    wr(8'h36, 16'h3F7E);               // only source 7 open
    out_check("R10 not yet", 3'd0, 8'h00);
    @(negedge clk);
    out_check("R10 R6 source 7 default vec", 3'd7, 8'h0F);
  endtask

  task automatic t_tie;
    wr(8'h44, 16'h0040);
    wr_settle(8'h36, 16'h0000);
    out_check("R2 tie 7 vs 8 lowest wins", 3'd7, 8'h0F);
    wr_settle(8'h1A, 16'h0000);        // ctrl 7 -> rank 0
    out_check("R6 watchdog vector", 3'd7, 8'h40);
  endtask

  task automatic t_uart;
    wr(8'h45, 16'h0041);
    wr(8'h46, 16'h0042);
    wr_settle(8'h1F, 16'h001D);        // ctrl 12
    out_check("R6 uart0 vector", 3'd7, 8'h41);
    wr_settle(8'h20, 16'h001E);        // ctrl 13
    out_check("R6 uart1 vector", 3'd7, 8'h42);
    wr_settle(8'h20, 16'h001D);
    out_check("R2 tie 12 vs 13", 3'd7, 8'h41);
  endtask

  task automatic t_auto;
    wr_settle(8'h16, 16'h009F);        // ctrl 3 rank 31 auto
    out_check("R5 autovector level 7", 3'd7, 8'd31);
    wr(8'h36, 16'h3FF6);               // only source 3 open
    wr_settle(8'h16, 16'h008B);
    out_check("R4 R5 level 2 autovector", 3'd2, 8'd26);
  endtask

  task automatic t_low;
    wr(8'h36, 16'h3FFA);               // only source 2 open
    wr_settle(8'h15, 16'h0003);
    out_check("R3 rank below 4", 3'd0, 8'h00);
    wr_settle(8'h15, 16'h0007);
    out_check("R4 level 1", 3'd1, 8'h0F);
  endtask

  task automatic t_release;
    @(negedge clk);
    irq_in = 13'h1FFD;                  // source 2 dropped (bit 2 of [13:1])
    @(negedge clk);
    out_check("R10 release one cycle", 3'd1, 8'h0F);
    @(negedge clk);
    out_check("R1 released source", 3'd0, 8'h00);
    rd_check("R9 pending after release", 8'h3A, 16'h3FFA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_masked;
    t_single;
    t_tie;
    t_uart;
    t_auto;
    t_low;
    t_release;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule